// File: doc/BRIEF.md
# Edge-Delay Calibration Register Bank

This block is the digital programming front end of a sixteen-channel drive-path deskew device. Each output channel has two delay settings, one for its rising edge and one for its falling edge. That makes thirty-two calibration registers, written from a parallel bus. Each register holds an eleven-bit code made of a coarse step field and a fine step field. Both fields are encoded wider than the delay line can use, so the block limits any out-of-range field to its highest usable value when the word is captured. It also raises a flag that stays set.

A low level on the mode pin selects calibration. In that mode a load strobe, qualified by two enable bits, captures the bus into a holding latch. One cycle later the latch commits into the addressed register. A high level on the mode pin selects the user mode. There every stored code is copied each cycle into the applied-code outputs that steer the delay lines, and strobes on the bus have no effect. The block also routes the data inputs to the channels. Split fanout feeds two groups of eight from two inputs. Single fanout feeds all sixteen channels from one common input. A registered readback port returns the stored code of the currently addressed register.

Top module: `dskw_cal_bank`

## Requirements
- R1: After reset, every stored code, every applied code, the readback port and the out-of-range flag are zero.
- R2: In calibration mode (`cal_mode_n` low), with `fn_en` equal to 2'b11 and `wr_stb` high at a rising edge, the bus word is captured at that edge and committed to the addressed register at the next edge. `rd_code` is registered and shows the stored code of the register selected by `addr` one edge after `addr` is applied.
- R3: Address bit 4 selects the edge (0 rising, 1 falling). Bits 3:0 select the channel. In the data word, bits 10:6 are the coarse field and bits 5:0 are the fine field.
- R4: A coarse field above 21 is stored as 21, and a fine field above 46 is stored as 46. The two fields are limited independently, and values at or below their limits are stored unchanged.
- R5: `oor_flag` goes high at the capture edge of any accepted write whose coarse or fine field exceeds its limit. It then stays high until reset. Accepted writes within range leave it unchanged.
- R6: A strobe while `cal_mode_n` is high, or while `fn_en` is not 2'b11, changes no register and does not set `oor_flag`.
- R7: While `cal_mode_n` is high, each applied output takes the stored code of its register at every edge. While `cal_mode_n` is low, the applied outputs hold their values.
- R8: The rising-edge and falling-edge codes of a channel are stored and applied independently. A write to one leaves the other unchanged.
- R9: With `fan_single` low, channels 0 to 7 carry `in_a` and channels 8 to 15 carry `in_b`. With `fan_single` high, all channels carry `in_all`. The routing is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_mode_n | input | 1 | 0 = calibration, 1 = user mode |
| wr_stb | input | 1 | Load strobe |
| fn_en | input | 2 | Write-qualifying enable bits, both must be 1 |
| addr | input | 5 | Register select: bit 4 edge, bits 3:0 channel |
| din | input | 11 | Delay word: coarse 10:6, fine 5:0 |
| fan_single | input | 1 | 0 = two groups of eight, 1 = one group of sixteen |
| in_a | input | 1 | Data input for channels 0 to 7 in split fanout |
| in_b | input | 1 | Data input for channels 8 to 15 in split fanout |
| in_all | input | 1 | Data input for all channels in single fanout |
| ch_in | output | 16 | Routed data per channel |
| rise_crs | output | 80 | Applied rising-edge coarse codes, 5 bits per channel |
| rise_fin | output | 96 | Applied rising-edge fine codes, 6 bits per channel |
| fall_crs | output | 80 | Applied falling-edge coarse codes, 5 bits per channel |
| fall_fin | output | 96 | Applied falling-edge fine codes, 6 bits per channel |
| rd_code | output | 11 | Registered stored code of the addressed register |
| oor_flag | output | 1 | Sticky out-of-range flag |

## Verification
A strobe sampled at edge k raises `oor_flag` right after edge k. The word lands in its register at edge k+1. It appears on `rd_code` one edge after the address is presented, and on the applied outputs at the first user-mode edge after the commit. `ch_in` follows its inputs within the same cycle. Each expected item in the scoreboard carries a due cycle counted from the clock edges that the driver knows about. The monitor compares only when the cycle counter reaches that value, sampling a few nanoseconds after the falling edge. The driver finishes each write two cycles after the strobe, so every read starts after the commit.

// File: rtl/dskw_pkg.sv
package dskw_pkg;
    localparam int DSK_NUM_CH = 16;
    localparam int DSK_CW     = 5;
    localparam int DSK_FW     = 6;
    localparam int DSK_CMAX   = 21;
    localparam int DSK_FMAX   = 46;
    localparam logic [1:0] DSK_EN_ALL = 2'b11;
endpackage

// File: rtl/dskw_clamp.sv
module dskw_clamp #(
    parameter int CW   = dskw_pkg::DSK_CW,
    parameter int FW   = dskw_pkg::DSK_FW,
    parameter int CMAX = dskw_pkg::DSK_CMAX,
    parameter int FMAX = dskw_pkg::DSK_FMAX,
    localparam int CODEW = CW + FW
) (
    input  logic [CODEW-1:0] raw,
    output logic [CODEW-1:0] lim,
    output logic             hit
);
    logic [CW-1:0] crs;
    logic [FW-1:0] fin;
    logic          crs_hi;
    logic          fin_hi;

    always_comb begin
        crs    = raw[CODEW-1:FW];
        fin    = raw[FW-1:0];
        crs_hi = crs > CW'(CMAX);
        fin_hi = fin > FW'(FMAX);
        lim    = {crs_hi ? CW'(CMAX) : crs, fin_hi ? FW'(FMAX) : fin};
        hit    = crs_hi | fin_hi;
    end
endmodule

// File: rtl/dskw_fanout.sv
module dskw_fanout #(
    parameter int NUM_CH = dskw_pkg::DSK_NUM_CH,
    localparam int HALF  = NUM_CH / 2
) (
    input  logic              fan_single,
    input  logic              in_a,
    input  logic              in_b,
    input  logic              in_all,
    output logic [NUM_CH-1:0] ch_in
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        if (c < HALF) begin : g_lo
            assign ch_in[c] = fan_single ? in_all : in_a;
        end else begin : g_hi
            assign ch_in[c] = fan_single ? in_all : in_b;
        end
    end
endmodule

// File: rtl/dskw_cal_bank.sv
module dskw_cal_bank #(
    parameter int NUM_CH = dskw_pkg::DSK_NUM_CH,
    parameter int CW     = dskw_pkg::DSK_CW,
    parameter int FW     = dskw_pkg::DSK_FW,
    parameter int CMAX   = dskw_pkg::DSK_CMAX,
    parameter int FMAX   = dskw_pkg::DSK_FMAX,
    localparam int CODEW = CW + FW,
    localparam int NREG  = 2 * NUM_CH,
    localparam int AW    = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cal_mode_n,
    input  logic                 wr_stb,
    input  logic [1:0]           fn_en,
    input  logic [AW-1:0]        addr,
    input  logic [CODEW-1:0]     din,
    input  logic                 fan_single,
    input  logic                 in_a,
    input  logic                 in_b,
    input  logic                 in_all,
    output logic [NUM_CH-1:0]    ch_in,
    output logic [NUM_CH*CW-1:0] rise_crs,
    output logic [NUM_CH*FW-1:0] rise_fin,
    output logic [NUM_CH*CW-1:0] fall_crs,
    output logic [NUM_CH*FW-1:0] fall_fin,
    output logic [CODEW-1:0]     rd_code,
    output logic                 oor_flag
);
    typedef struct packed {
        logic [NREG-1:0][CODEW-1:0] bank;
        logic [NREG-1:0][CODEW-1:0] app;
        logic [CODEW-1:0]           lat_code;
        logic [AW-1:0]              lat_addr;
        logic                       pend;
        logic                       oor;
        logic [CODEW-1:0]           rd;
    } st_t;

    st_t              st_d, st_q;
    logic [CODEW-1:0] lim_code;
    logic             lim_hit;
    logic             wr_take;

    dskw_clamp #(.CW(CW), .FW(FW), .CMAX(CMAX), .FMAX(FMAX)) u_clamp (
        .raw (din),
        .lim (lim_code),
        .hit (lim_hit)
    );

    dskw_fanout #(.NUM_CH(NUM_CH)) u_fan (
        .fan_single (fan_single),
        .in_a       (in_a),
        .in_b       (in_b),
        .in_all     (in_all),
        .ch_in      (ch_in)
    );

    assign wr_take = wr_stb && !cal_mode_n && (fn_en == dskw_pkg::DSK_EN_ALL);

    always_comb begin
        st_d = st_q;
        // capture stage: latch follows the bus while the strobe is accepted
        st_d.pend = wr_take;
        if (wr_take) begin
            st_d.lat_code = lim_code;
            st_d.lat_addr = addr;
            if (lim_hit) begin
                st_d.oor = 1'b1;
            end
        end
        // commit stage: end of the calibration cycle
        if (st_q.pend) begin
            st_d.bank[st_q.lat_addr] = st_q.lat_code;
        end
        st_d.rd = st_q.bank[addr];
        if (cal_mode_n) begin
            st_d.app = st_q.bank;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_out
        assign rise_crs[c*CW +: CW] = st_q.app[c][CODEW-1:FW];
        assign rise_fin[c*FW +: FW] = st_q.app[c][FW-1:0];
        assign fall_crs[c*CW +: CW] = st_q.app[NUM_CH+c][CODEW-1:FW];
        assign fall_fin[c*FW +: FW] = st_q.app[NUM_CH+c][FW-1:0];
    end

    assign rd_code  = st_q.rd;
    assign oor_flag = st_q.oor;
endmodule

// File: rtl/dskw_cal_chk.sv
module dskw_cal_chk #(
    parameter int NUM_CH = dskw_pkg::DSK_NUM_CH,
    parameter int CW     = dskw_pkg::DSK_CW,
    parameter int FW     = dskw_pkg::DSK_FW,
    parameter int CMAX   = dskw_pkg::DSK_CMAX,
    parameter int FMAX   = dskw_pkg::DSK_FMAX,
    localparam int CODEW = CW + FW,
    localparam int HALF  = NUM_CH / 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cal_mode_n,
    input logic                 wr_stb,
    input logic [1:0]           fn_en,
    input logic [CODEW-1:0]     din,
    input logic                 fan_single,
    input logic                 in_a,
    input logic                 in_b,
    input logic                 in_all,
    input logic [NUM_CH-1:0]    ch_in,
    input logic [NUM_CH*CW-1:0] rise_crs,
    input logic [NUM_CH*FW-1:0] rise_fin,
    input logic [NUM_CH*CW-1:0] fall_crs,
    input logic [NUM_CH*FW-1:0] fall_fin,
    input logic [CODEW-1:0]     rd_code,
    input logic                 oor_flag
);
    logic good_wr;
    logic wide_word;
    assign good_wr   = wr_stb && !cal_mode_n && (fn_en == 2'b11);
    assign wide_word = (din[CODEW-1:FW] > CW'(CMAX)) || (din[FW-1:0] > FW'(FMAX));

    assert_rd_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_code[CODEW-1:FW] <= CW'(CMAX)) && (rd_code[FW-1:0] <= FW'(FMAX)));

    assert_oor_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && wide_word) |=> oor_flag);

    assert_oor_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        oor_flag |=> oor_flag);

    assert_ignored_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !good_wr && !oor_flag) |=> !oor_flag);

    assert_applied_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_mode_n |=> ($stable(rise_crs) && $stable(rise_fin) &&
                         $stable(fall_crs) && $stable(fall_fin)));

    assert_fan_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fan_single |-> (ch_in == {NUM_CH{in_all}}));

    assert_fan_split_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fan_single |-> (ch_in == {{(NUM_CH-HALF){in_b}}, {HALF{in_a}}}));
endmodule

bind dskw_cal_bank dskw_cal_chk #(
    .NUM_CH(NUM_CH), .CW(CW), .FW(FW), .CMAX(CMAX), .FMAX(FMAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cal_mode_n(cal_mode_n), .wr_stb(wr_stb),
    .fn_en(fn_en), .din(din), .fan_single(fan_single), .in_a(in_a),
    .in_b(in_b), .in_all(in_all), .ch_in(ch_in), .rise_crs(rise_crs),
    .rise_fin(rise_fin), .fall_crs(fall_crs), .fall_fin(fall_fin),
    .rd_code(rd_code), .oor_flag(oor_flag)
);

// File: tb/sim_dskw_cal_bank.sv
module sim_dskw_cal_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_mode_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [1:0]  fn_en = 2'b00;
    logic [4:0]  addr = '0;
    logic [10:0] din = '0;
    logic        fan_single = 1'b0;
    logic        in_a = 1'b0;
    logic        in_b = 1'b0;
    logic        in_all = 1'b0;
    logic [15:0] ch_in;
    logic [79:0] rise_crs, fall_crs;
    logic [95:0] rise_fin, fall_fin;
    logic [10:0] rd_code;
    logic        oor_flag;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        int    kind;
        int    idx;
        int    exp;
        string tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dskw_cal_bank u0 (
        .clk(clk), .rst_n(rst_n), .cal_mode_n(cal_mode_n), .wr_stb(wr_stb),
        .fn_en(fn_en), .addr(addr), .din(din), .fan_single(fan_single),
        .in_a(in_a), .in_b(in_b), .in_all(in_all), .ch_in(ch_in),
        .rise_crs(rise_crs), .rise_fin(rise_fin), .fall_crs(fall_crs),
        .fall_fin(fall_fin), .rd_code(rd_code), .oor_flag(oor_flag)
    );

    function automatic int observe(int kind, int idx);
        case (kind)
            0: return int'(rd_code);
            1: return int'(oor_flag);
            2: return int'({rise_crs[idx*5 +: 5], rise_fin[idx*6 +: 6]});
            3: return int'({fall_crs[idx*5 +: 5], fall_fin[idx*6 +: 6]});
            default: return int'(ch_in);
        endcase
    endfunction

    // monitor: compares each scoreboard item when its cycle is reached
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                int    got;
                it  = sb.pop_front();
                got = observe(it.kind, it.idx);
                checks++;
                if (got != it.exp) begin
                    errors++;
                    $display("FAIL %s: kind %0d idx %0d actual %0h expected %0h",
                             it.tag, it.kind, it.idx, got, it.exp);
                end
            end
        end
    end

    task automatic expect_at(int delay, int kind, int idx, int exp, string tag);
        item_t it;
        it.due = cyc + delay; it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
        sb.push_back(it);
    endtask

    function automatic int code(int c, int f);
        return (c << 6) | f;
    endfunction

    // strobe at next edge; bank committed by the time the task returns
    task automatic put(logic [4:0] a, int c, int f, logic [1:0] en);
        @(negedge clk);
        addr = a; din = 11'(code(c, f)); fn_en = en; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0; fn_en = 2'b00;
        @(negedge clk);
    endtask

    task automatic get(logic [4:0] a, int exp, string tag);
        @(negedge clk);
        addr = a;
        expect_at(1, 0, 0, exp, tag);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_at(0, 1, 0, 0, "R1 flag");
        expect_at(0, 2, 0, 0, "R1 applied rise");
        expect_at(0, 3, 15, 0, "R1 applied fall");
        get(5'd0, 0, "R1 readback");

        // R2 R3 write rising ch3
        put(5'd3, 10, 20, 2'b11);
        get(5'd3, code(10, 20), "R2 R3 rise ch3");
        // R8 falling ch3 independent
        put(5'd19, 5, 7, 2'b11);
        get(5'd19, code(5, 7), "R8 fall ch3");
        get(5'd3, code(10, 20), "R8 rise ch3 kept");
        @(negedge clk); expect_at(0, 1, 0, 0, "R5 no flag in range");

        // R4 boundary and clamping
        put(5'd7, 21, 46, 2'b11);
        get(5'd7, code(21, 46), "R4 exact limits");
        @(negedge clk); expect_at(0, 1, 0, 0, "R5 limits do not flag");
        put(5'd5, 30, 10, 2'b11);
        get(5'd5, code(21, 10), "R4 coarse clamp");
        @(negedge clk); expect_at(0, 1, 0, 1, "R5 flag set");
        put(5'd6, 3, 63, 2'b11);
        get(5'd6, code(3, 46), "R4 fine clamp");

        // R6 ignored writes
        put(5'd8, 4, 4, 2'b01);
        get(5'd8, 0, "R6 enable not both");
        put(5'd24, 4, 4, 2'b10);
        get(5'd24, 0, "R6 enable other bit");

        // R7 user mode applies codes; R6 strobes ignored there
        @(negedge clk); cal_mode_n = 1'b1;
        @(negedge clk);
        expect_at(1, 2, 3, code(10, 20), "R7 applied rise ch3");
        expect_at(1, 3, 3, code(5, 7), "R7 applied fall ch3");
        expect_at(1, 2, 5, code(21, 10), "R7 applied rise ch5");
        put(5'd9, 9, 9, 2'b11);
        get(5'd9, 0, "R6 user-mode strobe ignored");
        // back to calibration: applied codes hold
        @(negedge clk); cal_mode_n = 1'b0;
        put(5'd3, 1, 2, 2'b11);
        get(5'd3, code(1, 2), "R2 rewrite rise ch3");
        @(negedge clk); expect_at(0, 2, 3, code(10, 20), "R7 held in cal mode");
        @(negedge clk); cal_mode_n = 1'b1;
        @(negedge clk); expect_at(1, 2, 3, code(1, 2), "R7 new code applied");
        @(negedge clk); expect_at(0, 3, 3, code(5, 7), "R8 fall unchanged");
        @(negedge clk); cal_mode_n = 1'b0;

        // R9 fanout
        @(negedge clk); fan_single = 1'b0; in_a = 1'b1; in_b = 1'b0; in_all = 1'b0;
        expect_at(0, 4, 0, 16'h00FF, "R9 split a");
        @(negedge clk); in_a = 1'b0; in_b = 1'b1;
        expect_at(0, 4, 0, 16'hFF00, "R9 split b");
        @(negedge clk); fan_single = 1'b1; in_all = 1'b1; in_b = 1'b0;
        expect_at(0, 4, 0, 16'hFFFF, "R9 single high");
        @(negedge clk); in_all = 1'b0; in_a = 1'b1; in_b = 1'b1;
        expect_at(0, 4, 0, 16'h0000, "R9 single ignores a b");

        @(negedge clk); expect_at(0, 1, 0, 1, "R5 flag sticky");
        repeat (4) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule